// File: doc/BRIEF.md
# Multichannel Zero-Data Detector

This block watches a set of PCM sample channels, one sample per channel on each frame strobe. It decides when a channel has carried nothing but zero data for a long, unbroken run of frames. Each channel keeps a saturating run counter. The channel's silence flag is raised once that counter reaches the run length, and it drops on the first non-zero sample. The flags are combined onto two indicator outputs. Each output has its own channel-select mask and is the AND of the flags of the channels that mask selects.

The indicators typically drive an external mute circuit. A global enable, a polarity invert and per-pair power-down inputs shape them. A soft-run bit acts as a soft reset: while it is low, the counters are cleared and both indicators report "silent". After soft-run returns high, that report is held for a few more frame strobes before the flags take over. Power-down treats a pair's samples as zero, so an idle pair never blocks detection on the active ones.

Top module: `zd_detector`

## Requirements
- R1: A channel's flag sets in the cycle after the RUN_LEN-th consecutive frame strobe whose sample was zero. It stays set while zero samples continue, because the counter saturates at RUN_LEN.
- R2: A frame strobe that carries a non-zero sample on a channel that is powered up clears that channel's run. The flag is low in the next cycle.
- R3: While `soft_run` is 0, or while `rst_n` is low, every run counter is cleared. Both indicators then report the detected level, which is 1 before the polarity step.
- R4: After `soft_run` rises, the detected level stays forced for HOLD_FRAMES further frame strobes. In the cycle after the HOLD_FRAMES-th strobe, the indicators follow the flags.
- R5: With `det_en` at 0, both `zero_a` and `zero_b` are 0.
- R6: `zero_a` is the AND of the flags of the channels whose bit is 1 in `mask_a`. `zero_b` is the same for `mask_b`. Bit c of each mask selects channel c.
- R7: An output whose mask is all zero gives 0 before the polarity step.
- R8: A channel in pair p (channels 2p and 2p+1) whose `pair_on[p]` is 0 has its samples treated as zero. When every bit of `pair_on` is 0, both outputs are 0.
- R9: With `det_inv` at 1, each output is the inverse of its pre-polarity value, unless R5 or R8 holds it at 0.
- R10: Samples presented without `frame_stb` have no effect on any run counter or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse marking a new frame's samples |
| samples | input | NUM_CH*SAMPLE_W | Channel c at bits [c*SAMPLE_W +: SAMPLE_W] |
| det_en | input | 1 | Detector enable; 0 holds both outputs low |
| det_inv | input | 1 | Polarity invert for both outputs |
| soft_run | input | 1 | 0 = soft reset, 1 = run |
| pair_on | input | NUM_CH/2 | Per-pair power; 0 = powered down |
| mask_a | input | NUM_CH | Channel select for zero_a |
| mask_b | input | NUM_CH | Channel select for zero_b |
| zero_a | output | 1 | Indicator A |
| zero_b | output | 1 | Indicator B |

## Verification
The bench builds the block with NUM_CH=4, SAMPLE_W=8, RUN_LEN=16 and HOLD_FRAMES=4. The short run length lets mostly-zero random data complete, and break, many saturating runs in a few thousand cycles. It also puts the exact set and clear boundaries and the release hold within a short directed sequence. Four channels in two pairs are enough to reach partial and full power-down, masks that select a subset or no channel, and masks that differ between the two outputs.

// File: rtl/zd_pkg.sv
package zd_pkg;
   localparam int unsigned ZD_NUM_OUT = 2;
   typedef enum logic {
      ZD_LVL_CLEAR  = 1'b0,
      ZD_LVL_DETECT = 1'b1
   } zd_level_e;
endpackage

// File: rtl/zd_run_counter.sv
module zd_run_counter #(
   parameter int unsigned SAMPLE_W = 24,
   parameter int unsigned RUN_LEN  = 8192,
   localparam int unsigned CNT_W   = $clog2(RUN_LEN + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_i,
   input  logic                stb_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic                pd_i,
   output logic                flag_o
);
   localparam logic [CNT_W-1:0] SAT = CNT_W'(RUN_LEN);

   logic [CNT_W-1:0] run_q;
   logic             live_data;

   assign live_data = (sample_i != '0) && !pd_i;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         run_q <= '0;
      end else if (stb_i) begin
         if (live_data)        run_q <= '0;
         else if (run_q != SAT) run_q <= run_q + 1'b1;
      end
   end

   assign flag_o = (run_q == SAT);

   p_sat_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= SAT);
   p_clear_on_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && live_data) |=> !flag_o);
   p_no_stb_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb_i && !clr_i) |=> $stable(run_q));
endmodule

// File: rtl/zd_release_timer.sv
module zd_release_timer #(
   parameter int unsigned HOLD_FRAMES = 4,
   localparam int unsigned HC_W       = $clog2(HOLD_FRAMES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic stb_i,
   output logic force_o
);
   localparam logic [HC_W-1:0] DONE = HC_W'(HOLD_FRAMES);

   logic [HC_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i)             hold_q <= '0;
      else if (stb_i && hold_q != DONE) hold_q <= hold_q + 1'b1;
   end

   assign force_o = !run_i || (hold_q != DONE);

   p_force_after_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !$past(run_i)) |-> force_o);
   p_no_refire_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!force_o && run_i) |=> (!force_o || !run_i));
endmodule

// File: rtl/zd_group_and.sv
module zd_group_and
   import zd_pkg::*;
#(
   parameter int unsigned NUM_CH = 8
) (
   input  logic [NUM_CH-1:0] flags_i,
   input  logic [NUM_CH-1:0] mask_i,
   input  logic              force_i,
   output zd_level_e         level_o
);
   logic all_sel_silent;

   assign all_sel_silent = &(flags_i | ~mask_i);

   always_comb begin
      if (force_i)                              level_o = ZD_LVL_DETECT;
      else if (mask_i != '0 && all_sel_silent)  level_o = ZD_LVL_DETECT;
      else                                      level_o = ZD_LVL_CLEAR;
   end
endmodule

// File: rtl/zd_detector.sv
module zd_detector
   import zd_pkg::*;
#(
   parameter int unsigned NUM_CH      = 8,
   parameter int unsigned SAMPLE_W    = 24,
   parameter int unsigned RUN_LEN     = 8192,
   parameter int unsigned HOLD_FRAMES = 4,
   localparam int unsigned NUM_PAIR   = NUM_CH / 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       frame_stb,
   input  logic [NUM_CH*SAMPLE_W-1:0] samples,
   input  logic                       det_en,
   input  logic                       det_inv,
   input  logic                       soft_run,
   input  logic [NUM_PAIR-1:0]        pair_on,
   input  logic [NUM_CH-1:0]          mask_a,
   input  logic [NUM_CH-1:0]          mask_b,
   output logic                       zero_a,
   output logic                       zero_b
);
   initial begin
      assert (NUM_CH >= 2 && NUM_CH % 2 == 0) else $error("NUM_CH must be even and >= 2");
      assert (SAMPLE_W >= 1) else $error("SAMPLE_W must be >= 1");
      assert (RUN_LEN >= 1) else $error("RUN_LEN must be >= 1");
      assert (HOLD_FRAMES >= 1) else $error("HOLD_FRAMES must be >= 1");
   end

   logic [NUM_CH-1:0]     ch_flag;
   logic                  hold_force;
   logic                  all_down;
   logic [NUM_CH-1:0]     sel_mask [ZD_NUM_OUT];
   zd_level_e             grp_lvl  [ZD_NUM_OUT];
   logic [ZD_NUM_OUT-1:0] ind;

   assign sel_mask[0] = mask_a;
   assign sel_mask[1] = mask_b;
   assign all_down    = (pair_on == '0);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      zd_run_counter #(
         .SAMPLE_W (SAMPLE_W),
         .RUN_LEN  (RUN_LEN)
      ) u_run (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr_i    (!soft_run),
         .stb_i    (frame_stb),
         .sample_i (samples[c*SAMPLE_W +: SAMPLE_W]),
         .pd_i     (!pair_on[c/2]),
         .flag_o   (ch_flag[c])
      );
   end

   zd_release_timer #(
      .HOLD_FRAMES (HOLD_FRAMES)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (soft_run),
      .stb_i   (frame_stb),
      .force_o (hold_force)
   );

   for (genvar g = 0; g < ZD_NUM_OUT; g++) begin : g_out
      zd_group_and #(
         .NUM_CH (NUM_CH)
      ) u_and (
         .flags_i (ch_flag),
         .mask_i  (sel_mask[g]),
         .force_i (hold_force),
         .level_o (grp_lvl[g])
      );
      assign ind[g] = (!det_en || all_down) ? 1'b0 : (grp_lvl[g] ^ det_inv);
   end

   assign zero_a = ind[0];
   assign zero_b = ind[1];

   p_en_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !det_en |-> (!zero_a && !zero_b));
   p_all_down_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_on == '0) |-> (!zero_a && !zero_b));
   p_soft_reset_det_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_run && det_en && !all_down) |-> (zero_a == !det_inv && zero_b == !det_inv));
   p_empty_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_force && mask_a == '0 && det_en && !all_down) |-> (zero_a == det_inv));
endmodule

// File: tb/zd_detector_tb.sv
module zd_detector_tb;
   localparam int NCH  = 4;
   localparam int W    = 8;
   localparam int RUN  = 16;
   localparam int HOLD = 4;

   logic clk = 0;
   logic rst_n = 0;
   logic frame_stb = 0;
   logic [NCH*W-1:0] samples = '0;
   logic det_en = 1, det_inv = 0, soft_run = 1;
   logic [NCH/2-1:0] pair_on = '1;
   logic [NCH-1:0] mask_a = '1, mask_b = '1;
   logic zero_a, zero_b;

   int n_chk = 0, n_bad = 0;
   int m_cnt [NCH];
   int m_hold;

   always #4 clk = ~clk;

   zd_detector #(.NUM_CH(NCH), .SAMPLE_W(W), .RUN_LEN(RUN), .HOLD_FRAMES(HOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .samples(samples),
      .det_en(det_en), .det_inv(det_inv), .soft_run(soft_run), .pair_on(pair_on),
      .mask_a(mask_a), .mask_b(mask_b), .zero_a(zero_a), .zero_b(zero_b));

   function automatic logic exp_out(input logic [NCH-1:0] m);
      logic raw;
      logic all;
      all = 1'b1;
      for (int c = 0; c < NCH; c++)
         if (m[c] && m_cnt[c] != RUN) all = 1'b0;
      if (!soft_run || m_hold != HOLD) raw = 1'b1;
      else raw = (m != '0) && all;
      if (!det_en || pair_on == '0) return 1'b0;
      return raw ^ det_inv;
   endfunction

   task automatic model_update();
      if (!rst_n || !soft_run) begin
         for (int c = 0; c < NCH; c++) m_cnt[c] = 0;
         m_hold = 0;
      end else if (frame_stb) begin
         for (int c = 0; c < NCH; c++) begin
            if (samples[c*W +: W] != '0 && pair_on[c/2]) m_cnt[c] = 0;
            else if (m_cnt[c] != RUN) m_cnt[c]++;
         end
         if (m_hold != HOLD) m_hold++;
      end
   endtask

   task automatic check(input string tag);
      logic ea, eb;
      ea = exp_out(mask_a);
      eb = exp_out(mask_b);
      n_chk++;
      if (zero_a !== ea || zero_b !== eb) begin
         n_bad++;
         $display("FAIL %s: zero_a/zero_b got %b%b expected %b%b at %0t", tag, zero_a, zero_b, ea, eb, $time);
      end
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_update();
      #2;
      check(tag);
   endtask

   task automatic frames(input int n, input logic [NCH*W-1:0] d, input string tag);
      for (int i = 0; i < n; i++) begin
         samples = d; frame_stb = 1;
         step(tag);
      end
      frame_stb = 0;
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < NCH; c++) m_cnt[c] = 0;
      m_hold = 0;
      step("R3"); step("R3");
      #1 check("R3");
      rst_n = 1;
      frames(HOLD, '0, "R4");
      frames(RUN - HOLD - 1, '0, "R1");
      frames(2, '0, "R1");
      frames(3, '0, "R1");
      frames(1, {{(NCH-1)*W{1'b0}}, 8'h01}, "R2");
      samples = '1; frame_stb = 0;
      for (int i = 0; i < 5; i++) step("R10");
      mask_a = 4'b1110; mask_b = 4'b0001;
      #1 check("R6");
      frames(RUN, '0, "R6");
      mask_b = '0;
      #1 check("R7");
      det_inv = 1;
      #1 check("R9");
      det_en = 0;
      #1 check("R5");
      det_en = 1;
      frames(1, '1, "R2");
      pair_on = 2'b10;
      frames(RUN, {{2*W{1'b0}}, {2*W{1'b1}}}, "R8");
      pair_on = '0;
      #1 check("R8");
      pair_on = '1; det_inv = 0; mask_a = '1; mask_b = 4'b0011;
      soft_run = 0;
      step("R3"); step("R3");
      soft_run = 1;
      frames(HOLD + 2, {NCH{8'h05}}, "R4");
      for (int i = 0; i < 6000; i++) begin
         frame_stb = ($urandom % 4) != 0;
         for (int c = 0; c < NCH; c++)
            samples[c*W +: W] = (($urandom % 24) == 0) ? 8'($urandom) : 8'h00;
         if ($urandom % 200 == 0) mask_a = 4'($urandom);
         if ($urandom % 200 == 0) mask_b = 4'($urandom);
         if ($urandom % 300 == 0) det_inv = ~det_inv;
         if ($urandom % 400 == 0) det_en = ~det_en;
         if ($urandom % 300 == 0) pair_on = 2'($urandom);
         soft_run = ($urandom % 500) != 0;
         step("R6");
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0a11));
   end
endmodule